// File: doc/BRIEF.md
# Shunt Current Sampling Scheduler

This block times low-side shunt current measurements against a center-aligned space-vector PWM period. A phase's current is only visible on its shunt while that phase's bottom switch conducts. The block therefore watches the period counter and fires one ADC start pulse at the middle of every period. With that pulse it names the two phases to convert. The pair is chosen from the active sector so that the phase with the highest duty, whose low side may never turn on, is never sampled.

Each period it also tests the low-side window of the two sampled phases. The window is the period length, less the larger of the two compare values, less the dead-time. It must be at least twice the ADC sample time, because the conversion starts at the window's centre. When the two signed conversion results come back, the block derives the third current from the rule that the three currents sum to zero. It then presents all three currents with a one-cycle valid strobe. Any period that fails the window test yields no strobe, and the old currents stay on the outputs.

Top module: `shunt_sample_sched`

## Requirements
- R1: The sector code is captured on the clock edge where `cnt_i == period_i - 1` (counter wrap), and that captured value alone steers the next period; changes of `sector_i` at other times have no effect on that period.
- R2: For a legal captured sector, `trig_o` is high for exactly one cycle, in the cycle after the edge that samples `cnt_i == period_i >> 1`. This happens once per period.
- R3: `pair_o` is updated together with the trigger and held until the next trigger. Code 0 = phases b,c (sectors 1 and 6); code 1 = phases a,c (sectors 2 and 3); code 2 = phases a,b (sectors 4 and 5). Code 3 is never issued.
- R4: Sector codes 0 and 7 are illegal. A wrap that captures one sets `sec_err_o` and suppresses that period's trigger. A wrap that captures a legal code clears `sec_err_o`.
- R5: The low-side window is `period_i - max(selected compares) - dead_i`, computed as a signed value. A violation exists when `2*tsmp_i` exceeds it (a negative window always violates). `win_err_o` carries the verdict, is registered with the trigger, and is held until the next trigger.
- R6: After a trigger, the first `adc_vld_i` beat is the alphabetically earlier phase of the pair, and the second beat is the other phase. Beats that arrive with no trigger pending are ignored.
- R7: The unsampled current equals minus the sum of the two sampled ones, on outputs two bits wider than the ADC data. `cur_vld_o` pulses for one cycle, in the cycle after the edge that accepts the second beat.
- R8: In a period flagged by `win_err_o`, no `cur_vld_o` pulse is produced and all three current outputs keep their previous values.
- R9: After reset, the trigger, valid strobe and both error flags are low, and all three currents are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sector_i | input | 3 | Active sector, 1 to 6 legal |
| cnt_i | input | CNT_W | PWM period counter, 0 to period_i-1 |
| period_i | input | CNT_W | PWM period length in ticks |
| cmp_a_i | input | CNT_W | Phase a high-side compare (duty ticks) |
| cmp_b_i | input | CNT_W | Phase b high-side compare (duty ticks) |
| cmp_c_i | input | CNT_W | Phase c high-side compare (duty ticks) |
| dead_i | input | CNT_W | Dead-time in ticks |
| tsmp_i | input | CNT_W | ADC sample duration in ticks |
| adc_vld_i | input | 1 | ADC result beat valid |
| adc_data_i | input | CUR_W | Signed ADC result |
| trig_o | output | 1 | ADC start pulse |
| pair_o | output | 2 | Channel pair code |
| win_err_o | output | 1 | Sampling window too short this period |
| sec_err_o | output | 1 | Illegal sector captured |
| cur_vld_o | output | 1 | Rebuilt currents valid strobe |
| ia_o | output | CUR_W+2 | Phase a current, signed |
| ib_o | output | CUR_W+2 | Phase b current, signed |
| ic_o | output | CUR_W+2 | Phase c current, signed |

## Verification
The bench drives the sector only in the period before the one it checks, and holds it at an illegal value during the checked period. A design that reads the sector live instead of capturing it at the wrap would then lose its trigger. The window test is probed at exact equality, one tick past equality, and with a negative window; an unsigned or off-by-one comparison would flip one of those verdicts. Full-scale ADC values of both signs catch a rebuild that is too narrow and wraps the derived current. ADC beats are injected in periods with no trigger, and they must leave the outputs untouched. After a window violation the bench checks that the previous currents are still held.

// File: rtl/ssched_pkg.sv
package ssched_pkg;

  typedef enum logic [1:0] {
    PAIR_BC   = 2'd0,
    PAIR_AC   = 2'd1,
    PAIR_AB   = 2'd2,
    PAIR_NONE = 2'd3
  } pair_e;

  // Map a sector code to the phase pair whose low sides are sure to conduct.
  function automatic pair_e sector_to_pair(input logic [2:0] code);
    pair_e p;
    case (code)
      3'd1, 3'd6: p = PAIR_BC;
      3'd2, 3'd3: p = PAIR_AC;
      3'd4, 3'd5: p = PAIR_AB;
      default:    p = PAIR_NONE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ssched_sector_map.sv
module ssched_sector_map
  import ssched_pkg::*;
(
  input  logic [2:0] code_i,
  output pair_e      pair_o,
  output logic       legal_o
);

  always_comb begin
    pair_o  = sector_to_pair(code_i);
    legal_o = (pair_o != PAIR_NONE);
  end

endmodule

// File: rtl/ssched_window.sv
module ssched_window
  import ssched_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  pair_e            pair_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_b_i,
  input  logic [CNT_W-1:0] cmp_c_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic [CNT_W-1:0] tsmp_i,
  output logic             viol_o
);

  localparam int WW = CNT_W + 2;

  logic [CNT_W-1:0]    cmp_x;
  logic [CNT_W-1:0]    cmp_y;
  logic [CNT_W-1:0]    cmp_max;
  logic signed [WW-1:0] low_time;
  logic signed [WW-1:0] need;

  always_comb begin
    case (pair_i)
      PAIR_BC: begin cmp_x = cmp_b_i; cmp_y = cmp_c_i; end
      PAIR_AC: begin cmp_x = cmp_a_i; cmp_y = cmp_c_i; end
      PAIR_AB: begin cmp_x = cmp_a_i; cmp_y = cmp_b_i; end
      default: begin cmp_x = '0;      cmp_y = '0;      end
    endcase
    cmp_max  = (cmp_x > cmp_y) ? cmp_x : cmp_y;
    low_time = $signed({2'b00, period_i}) - $signed({2'b00, cmp_max})
             - $signed({2'b00, dead_i});
    need     = $signed({1'b0, tsmp_i, 1'b0});
    viol_o   = (need > low_time);
  end

endmodule

// File: rtl/ssched_rebuild.sv
module ssched_rebuild
  import ssched_pkg::*;
#(
  parameter int CUR_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    arm_i,
  input  pair_e                   pair_i,
  input  logic                    bad_i,
  input  logic                    adc_vld_i,
  input  logic signed [CUR_W-1:0] adc_data_i,
  output logic                    vld_o,
  output logic signed [CUR_W+1:0] ia_o,
  output logic signed [CUR_W+1:0] ib_o,
  output logic signed [CUR_W+1:0] ic_o
);

  localparam int OW = CUR_W + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND} st_e;

  st_e                    st_q, st_d;
  logic signed [CUR_W-1:0] first_q, first_d;
  logic signed [OW-1:0]   ia_q, ib_q, ic_q, ia_d, ib_d, ic_d;
  logic                   vld_q, vld_d;
  logic signed [OW-1:0]   s0, s1, neg;
  logic                   finish;

  always_comb begin
    st_d    = st_q;
    first_d = first_q;
    finish  = 1'b0;
    if (arm_i) begin
      st_d = ST_FIRST;
    end else begin
      case (st_q)
        ST_FIRST: if (adc_vld_i) begin
          first_d = adc_data_i;
          st_d    = ST_SECOND;
        end
        ST_SECOND: if (adc_vld_i) begin
          finish = 1'b1;
          st_d   = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    s0   = OW'(first_q);
    s1   = OW'(adc_data_i);
    neg  = -(s0 + s1);
    ia_d = ia_q;
    ib_d = ib_q;
    ic_d = ic_q;
    vld_d = 1'b0;
    if (finish && !bad_i) begin
      vld_d = 1'b1;
      case (pair_i)
        PAIR_BC: begin ia_d = neg; ib_d = s0;  ic_d = s1;  end
        PAIR_AC: begin ia_d = s0;  ib_d = neg; ic_d = s1;  end
        PAIR_AB: begin ia_d = s0;  ib_d = s1;  ic_d = neg; end
        default: vld_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      first_q <= '0;
      ia_q    <= '0;
      ib_q    <= '0;
      ic_q    <= '0;
      vld_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      first_q <= first_d;
      ia_q    <= ia_d;
      ib_q    <= ib_d;
      ic_q    <= ic_d;
      vld_q   <= vld_d;
    end
  end

  assign vld_o = vld_q;
  assign ia_o  = ia_q;
  assign ib_o  = ib_q;
  assign ic_o  = ic_q;

endmodule

// File: rtl/shunt_sample_sched.sv
module shunt_sample_sched
  import ssched_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int CUR_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              sector_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [CNT_W-1:0]        period_i,
  input  logic [CNT_W-1:0]        cmp_a_i,
  input  logic [CNT_W-1:0]        cmp_b_i,
  input  logic [CNT_W-1:0]        cmp_c_i,
  input  logic [CNT_W-1:0]        dead_i,
  input  logic [CNT_W-1:0]        tsmp_i,
  input  logic                    adc_vld_i,
  input  logic signed [CUR_W-1:0] adc_data_i,
  output logic                    trig_o,
  output logic [1:0]              pair_o,
  output logic                    win_err_o,
  output logic                    sec_err_o,
  output logic                    cur_vld_o,
  output logic signed [CUR_W+1:0] ia_o,
  output logic signed [CUR_W+1:0] ib_o,
  output logic signed [CUR_W+1:0] ic_o
);

  pair_e pair_in;
  logic  legal_in;
  pair_e sel_q, sel_d;
  logic  legal_q, legal_d;
  logic  sec_err_q, sec_err_d;
  pair_e pair_q, pair_d;
  logic  trig_q, trig_d;
  logic  win_q, win_d;
  logic  wrap, mid, fire, viol;

  ssched_sector_map u_map (
    .code_i  (sector_i),
    .pair_o  (pair_in),
    .legal_o (legal_in)
  );

  ssched_window #(.CNT_W(CNT_W)) u_win (
    .pair_i   (sel_q),
    .period_i (period_i),
    .cmp_a_i  (cmp_a_i),
    .cmp_b_i  (cmp_b_i),
    .cmp_c_i  (cmp_c_i),
    .dead_i   (dead_i),
    .tsmp_i   (tsmp_i),
    .viol_o   (viol)
  );

  // Period event decode and next-state.
  always_comb begin
    wrap = (cnt_i == (period_i - 1'b1));
    mid  = (cnt_i == (period_i >> 1));
    fire = mid && legal_q;

    sel_d     = sel_q;
    legal_d   = legal_q;
    sec_err_d = sec_err_q;
    if (wrap) begin
      sel_d     = pair_in;
      legal_d   = legal_in;
      sec_err_d = !legal_in;
    end

    trig_d = fire;
    pair_d = pair_q;
    win_d  = win_q;
    if (fire) begin
      pair_d = sel_q;
      win_d  = viol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= PAIR_NONE;
      legal_q   <= 1'b0;
      sec_err_q <= 1'b0;
      pair_q    <= PAIR_BC;
      trig_q    <= 1'b0;
      win_q     <= 1'b0;
    end else begin
      sel_q     <= sel_d;
      legal_q   <= legal_d;
      sec_err_q <= sec_err_d;
      pair_q    <= pair_d;
      trig_q    <= trig_d;
      win_q     <= win_d;
    end
  end

  ssched_rebuild #(.CUR_W(CUR_W)) u_rebuild (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (fire),
    .pair_i     (pair_q),
    .bad_i      (win_q),
    .adc_vld_i  (adc_vld_i),
    .adc_data_i (adc_data_i),
    .vld_o      (cur_vld_o),
    .ia_o       (ia_o),
    .ib_o       (ib_o),
    .ic_o       (ic_o)
  );

  assign trig_o    = trig_q;
  assign pair_o    = pair_q;
  assign win_err_o = win_q;
  assign sec_err_o = sec_err_q;

endmodule

// File: rtl/ssched_chk.sv
module ssched_chk #(
  parameter int CNT_W = 12,
  parameter int CUR_W = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [CNT_W-1:0]        cnt_i,
  input logic [CNT_W-1:0]        period_i,
  input logic                    trig_o,
  input logic [1:0]              pair_o,
  input logic                    win_err_o,
  input logic                    sec_err_o,
  input logic                    cur_vld_o,
  input logic signed [CUR_W+1:0] ia_o,
  input logic signed [CUR_W+1:0] ib_o,
  input logic signed [CUR_W+1:0] ic_o
);

  logic signed [CUR_W+3:0] sum3;
  assign sum3 = (CUR_W+4)'(ia_o) + (CUR_W+4)'(ib_o) + (CUR_W+4)'(ic_o);

  a_r2_trig_at_mid: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> ($past(cnt_i) == ($past(period_i) >> 1)));

  a_r2_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  a_r3_pair_legal: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> (pair_o != 2'd3));

  a_r3_pair_held: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_o |-> $stable(pair_o));

  a_r4_no_trig_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> !sec_err_o);

  a_r5_win_held: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_o |-> $stable(win_err_o));

  a_r7_zero_sum: assert property (@(posedge clk) disable iff (!rst_n)
    cur_vld_o |-> (sum3 == '0));

  a_r8_no_vld_on_viol: assert property (@(posedge clk) disable iff (!rst_n)
    cur_vld_o |-> !win_err_o);

  a_r8_hold_currents: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_vld_o |-> ($stable(ia_o) && $stable(ib_o) && $stable(ic_o)));

endmodule

bind shunt_sample_sched ssched_chk #(.CNT_W(CNT_W), .CUR_W(CUR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_i     (cnt_i),
  .period_i  (period_i),
  .trig_o    (trig_o),
  .pair_o    (pair_o),
  .win_err_o (win_err_o),
  .sec_err_o (sec_err_o),
  .cur_vld_o (cur_vld_o),
  .ia_o      (ia_o),
  .ib_o      (ib_o),
  .ic_o      (ic_o)
);

// File: tb/shunt_sample_sched_tb_top.sv
`timescale 1ns/1ps
module shunt_sample_sched_tb_top;

  localparam int CNT_W = 12;
  localparam int CUR_W = 12;
  localparam int P     = 100;

  logic                    clk;
  logic                    rst_n;
  logic [2:0]              sector_i;
  logic [CNT_W-1:0]        cnt_i, period_i, cmp_a_i, cmp_b_i, cmp_c_i, dead_i, tsmp_i;
  logic                    adc_vld_i;
  logic signed [CUR_W-1:0] adc_data_i;
  logic                    trig_o, win_err_o, sec_err_o, cur_vld_o;
  logic [1:0]              pair_o;
  logic signed [CUR_W+1:0] ia_o, ib_o, ic_o;

  int checks = 0;
  int fails  = 0;

  shunt_sample_sched #(.CNT_W(CNT_W), .CUR_W(CUR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sector_i(sector_i), .cnt_i(cnt_i),
    .period_i(period_i), .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i),
    .cmp_c_i(cmp_c_i), .dead_i(dead_i), .tsmp_i(tsmp_i),
    .adc_vld_i(adc_vld_i), .adc_data_i(adc_data_i), .trig_o(trig_o),
    .pair_o(pair_o), .win_err_o(win_err_o), .sec_err_o(sec_err_o),
    .cur_vld_o(cur_vld_o), .ia_o(ia_o), .ib_o(ib_o), .ic_o(ic_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [2:0]         sec;
    logic [11:0]        ca, cb, cc, dt, ts;
    logic signed [11:0] r0, r1;
    logic               etrig;
    logic [1:0]         epair;
    logic               ewin;
    logic               evld;
    logic signed [13:0] ea, eb, ec;
    logic               esec;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 12'd90, 12'd60, 12'd20, 12'd4, 12'd10,  12'sd100,  -12'sd30,  1'b1, 2'd0, 1'b0, 1'b1,   -14'sd70,   14'sd100,   -14'sd30, 1'b0},
    '{3'd2, 12'd70, 12'd80, 12'd30, 12'd4, 12'd10,  -12'sd50,   12'sd20,  1'b1, 2'd1, 1'b0, 1'b1,   -14'sd50,    14'sd30,    14'sd20, 1'b0},
    '{3'd3, 12'd40, 12'd95, 12'd10, 12'd2, 12'd5,   12'sd200, -12'sd500,  1'b1, 2'd1, 1'b0, 1'b1,   14'sd200,   14'sd300,  -14'sd500, 1'b0},
    '{3'd4, 12'd50, 12'd45, 12'd99, 12'd3, 12'd8,     12'sd7,   -12'sd3,  1'b1, 2'd2, 1'b0, 1'b1,     14'sd7,    -14'sd3,    -14'sd4, 1'b0},
    '{3'd5, 12'd30, 12'd30, 12'd90, 12'd2, 12'd9,  -12'sd2048, -12'sd2048, 1'b1, 2'd2, 1'b0, 1'b1, -14'sd2048, -14'sd2048,  14'sd4096, 1'b0},
    '{3'd6, 12'd95, 12'd20, 12'd55, 12'd5, 12'd10, 12'sd2047,  12'sd2047, 1'b1, 2'd0, 1'b0, 1'b1, -14'sd4094,  14'sd2047,  14'sd2047, 1'b0},
    '{3'd1, 12'd90, 12'd60, 12'd20, 12'd4, 12'd18,    12'sd1,    12'sd2,  1'b1, 2'd0, 1'b0, 1'b1,    -14'sd3,     14'sd1,     14'sd2, 1'b0},
    '{3'd1, 12'd90, 12'd60, 12'd20, 12'd4, 12'd19,    12'sd5,    12'sd5,  1'b1, 2'd0, 1'b1, 1'b0,    -14'sd3,     14'sd1,     14'sd2, 1'b0},
    '{3'd4, 12'd99, 12'd10, 12'd50, 12'd4, 12'd0,     12'sd9,    12'sd9,  1'b1, 2'd2, 1'b1, 1'b0,    -14'sd3,     14'sd1,     14'sd2, 1'b0},
    '{3'd0, 12'd10, 12'd10, 12'd10, 12'd1, 12'd1,    12'sd11,   12'sd12,  1'b0, 2'd2, 1'b1, 1'b0,    -14'sd3,     14'sd1,     14'sd2, 1'b1},
    '{3'd7, 12'd10, 12'd10, 12'd10, 12'd1, 12'd1,    12'sd13,   12'sd14,  1'b0, 2'd2, 1'b1, 1'b0,    -14'sd3,     14'sd1,     14'sd2, 1'b1},
    '{3'd3, 12'd10, 12'd50, 12'd10, 12'd0, 12'd0,     12'sd3,    12'sd4,  1'b1, 2'd1, 1'b0, 1'b1,     14'sd3,    -14'sd7,     14'sd4, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Pre-period: present the sector so it is captured at the wrap.
  task automatic pre_period(input logic [2:0] sec);
    for (int c = 0; c < P; c++) begin
      @(negedge clk);
      cnt_i     = CNT_W'(c);
      sector_i  = sec;
      adc_vld_i = 1'b0;
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int trig_n = 0;
    int vld_n  = 0;
    int stage  = 0;
    logic [1:0] pair_seen = 2'd3;
    logic signed [13:0] oa, ob, oc;
    cmp_a_i = v.ca; cmp_b_i = v.cb; cmp_c_i = v.cc;
    dead_i  = v.dt; tsmp_i  = v.ts;
    pre_period(v.sec);
    oa = 0; ob = 0; oc = 0;
    for (int c = 0; c < P; c++) begin
      @(negedge clk);
      if (trig_o) begin trig_n++; pair_seen = pair_o; stage = 1; end
      if (cur_vld_o) vld_n++;
      if (!v.etrig && c == 60) stage = 1;   // R6: stray beats with no trigger
      cnt_i    = CNT_W'(c);
      sector_i = 3'd0;                      // R1: live value must not matter
      case (stage)
        1: begin adc_vld_i = 1'b1; adc_data_i = v.r0; stage = 2; end
        2: begin adc_vld_i = 1'b1; adc_data_i = v.r1; stage = 3; end
        default: begin adc_vld_i = 1'b0; stage = 0; end
      endcase
    end
    oa = ia_o; ob = ib_o; oc = ic_o;
    check(trig_n == (v.etrig ? 1 : 0), $sformatf("R2/R4 vec%0d trigger count", idx), trig_n, v.etrig ? 1 : 0);
    if (v.etrig)
      check(pair_seen == v.epair, $sformatf("R3 vec%0d pair code", idx), pair_seen, v.epair);
    check(win_err_o == v.ewin, $sformatf("R5 vec%0d window flag", idx), win_err_o, v.ewin);
    check(sec_err_o == v.esec, $sformatf("R4 vec%0d sector error", idx), sec_err_o, v.esec);
    check(vld_n == (v.evld ? 1 : 0), $sformatf("R7/R8 vec%0d valid strobes", idx), vld_n, v.evld ? 1 : 0);
    check(oa == v.ea, $sformatf("R7/R8 vec%0d ia", idx), oa, v.ea);
    check(ob == v.eb, $sformatf("R7/R8 vec%0d ib", idx), ob, v.eb);
    check(oc == v.ec, $sformatf("R7/R8 vec%0d ic", idx), oc, v.ec);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    sector_i = 3'd0; cnt_i = '0; period_i = CNT_W'(P);
    cmp_a_i = '0; cmp_b_i = '0; cmp_c_i = '0; dead_i = '0; tsmp_i = '0;
    adc_vld_i = 1'b0; adc_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R9: reset state
    check(trig_o == 1'b0, "R9 trig after reset", trig_o, 0);
    check(cur_vld_o == 1'b0, "R9 valid after reset", cur_vld_o, 0);
    check(win_err_o == 1'b0, "R9 window flag after reset", win_err_o, 0);
    check(sec_err_o == 1'b0, "R9 sector error after reset", sec_err_o, 0);
    check(ia_o == 0 && ib_o == 0 && ic_o == 0, "R9 currents after reset", ia_o, 0);

    // R6: beats with nothing pending before any trigger leave outputs at zero
    adc_vld_i = 1'b1; adc_data_i = 12'sd55;
    @(negedge clk);
    adc_data_i = 12'sd66;
    @(negedge clk);
    adc_vld_i = 1'b0;
    @(negedge clk);
    check(cur_vld_o == 1'b0 && ia_o == 0, "R6 stray beats ignored", ia_o, 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    summary();
  end

endmodule